// File: doc/BRIEF.md
# Snapshot-Latched Time Counters

This block keeps time of day in four cascaded counters (hundredths of a second, seconds, minutes, hours) that advance on a single-cycle 100 Hz tick pulse. A processor reaches it over a small parallel bus. The bus has an active-low chip select and separate active-low read and write strobes. A run bit in a command register decides whether ticks reach the counters. To set the time, software clears the run bit, loads the counters, and sets the run bit again.

A multi-byte time value can tear if it changes between byte reads. To avoid this, the block freezes a copy of the time. When a read of the hundredths counter begins, all counters are copied into a 36-bit holding latch. Reads of seconds, minutes and hours then return the held copy until the next hundredths read.

While any bus access is active, incoming ticks are held back, so the value being read cannot move. One held tick is applied on the first clock after the access ends. Any further ticks that arrive during the same access are lost.

Top module: `rtc_snapshot_counters`

## Requirements
- R1: After reset, all counters, the holding latch and the command register are zero. `rdata` is zero whenever no read is active.
- R2: A read is active while `cs_n` and `rd_n` are both low. The register returned depends on `addr`:
  - 0 returns the live hundredths.
  - 1, 2 and 3 return the latched seconds, minutes and hours.
  - 4 returns the command register.
  - 5 and 6 return the spare upper latch bits, which are always zero.
  - 7 returns zero.
- R3: Bit 3 of the command register (the run bit) lets ticks advance the counters when it is 1. When it is 0, ticks are ignored.
- R4: The moduli are 100, 60, 60 and 24, for hundredths, seconds, minutes and hours in that order. On the clock where a counter wraps to zero, it also increments the next counter. Time 23:59:59.99 advances to all zeros.
- R5: A write clock has `cs_n` and `wr_n` low with `rd_n` high. On such a clock:
  - Addresses 0 to 3 load the live counter directly, and a value at or above that counter's modulus loads 0.
  - Address 4 loads the command register.
  - Writes never change the holding latch.
- R6: On the first clock of a read at address 0, the latch captures the live counters. Later reads at addresses 1 to 3 return that capture until the next address-0 read begins.
- R7: A tick that arrives while a read is active is held, and the counters do not change during the read. The held tick is applied on the first clock after the read ends. If a new tick arrives on that same clock, it is applied on the clock after.
- R8: At most one tick is held. Further ticks that arrive during the same read are dropped.
- R9: A write attempted while a read is active has no effect. A tick that arrives during a write clock is held and applied after the write, in the same way as during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_100hz | input | 1 | Single-cycle 100 Hz advance pulse |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when no read is active |

## Verification
The bench sets the time to 23:59:59.98, steps it across midnight, and checks that every field returns to zero. A broken carry chain would leave hours at 23 or skip a second.

It holds a hundredths read open across one tick, then across four ticks, and then releases a read on the same cycle that a fresh tick arrives. A design that lost the held tick, counted every tick, or merged the two final ticks would be off by one.

It writes values at or above the modulus, and rewrites seconds after taking a snapshot. This exposes a design that stores out-of-range values or lets writes disturb the latch.

It also overlaps a write with a read, and a tick with a write, to show that the overlapping write is blocked and the tick is deferred.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

  localparam int NUM_STAGES = 4;
  localparam int CMD_RUN_BIT = 3;
  localparam int ADDR_CMD = 4;

  // modulus of each cascade stage, lowest first
  function automatic int stage_mod(input int idx);
    case (idx)
      0: return 100;
      1: return 60;
      2: return 60;
      default: return 24;
    endcase
  endfunction

  function automatic int stage_width(input int idx);
    return $clog2(stage_mod(idx));
  endfunction

  // bit offset of a stage inside the packed time vector
  function automatic int stage_lsb(input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += stage_width(k);
    return acc;
  endfunction

  localparam int LIVE_W = stage_lsb(NUM_STAGES);

  // value stored by a write: out-of-range loads become zero
  function automatic int clamp_load(input int v, input int modv);
    return (v >= modv) ? 0 : v;
  endfunction

  // one increment with wrap at the modulus
  function automatic int next_count(input int v, input int modv);
    return (v >= modv - 1) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/rtc_count_stage.sv
module rtc_count_stage
  import rtc_snap_pkg::*;
#(
  parameter int MOD = 60,
  parameter int DATA_W = 8,
  localparam int W = $clog2(MOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_data,
  output logic [W-1:0]      val,
  output logic              carry
);

  assign carry = inc && (val == W'(MOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   val <= '0;
    else if (ld)  val <= W'(clamp_load(int'(ld_data), MOD));
    else if (inc) val <= W'(next_count(int'(val), MOD));
  end

  // R4: a stage never leaves its range
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(val) < MOD);

  // R4: the last value rolls to zero on an increment
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && val == W'(MOD - 1)) |=> (val == '0));

endmodule

// File: rtl/rtc_tick_hold.sv
module rtc_tick_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic hold,
  output logic step,
  output logic pending
);

  logic eff_tick;

  assign eff_tick = tick && run;
  assign step     = !hold && (pending || eff_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pending <= 1'b0;
    else if (hold) pending <= pending || eff_tick;
    else           pending <= pending && eff_tick;
  end

  // R8: once held, the tick stays held until the access ends
  a_r8_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && pending) |=> pending);

  // R7: a held tick is released as soon as the access ends
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && pending) |-> step);

endmodule

// File: rtl/rtc_snap_latch.sv
module rtc_snap_latch #(
  parameter int LIVE_W = 24,
  parameter int LATCH_W = 36
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [LIVE_W-1:0]  live,
  output logic [LATCH_W-1:0] held
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (capture) held <= LATCH_W'(live);
  end

  // R6: a capture copies the time present at that edge
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (held[LIVE_W-1:0] == $past(live)));

  // R2: spare bits stay zero
  a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    held[LATCH_W-1:LIVE_W] == '0);

endmodule

// File: rtl/rtc_snapshot_counters.sv
module rtc_snapshot_counters
  import rtc_snap_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int LATCH_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_100hz,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int SPARE_HI_W = LATCH_W - LIVE_W - DATA_W;

  logic                read_act, write_act, read_act_q, snap_pulse, hold;
  logic                step, pending, day_roll, cmd_run;
  logic [DATA_W-1:0]   cmd_q;
  logic [LIVE_W-1:0]   live;
  logic [LATCH_W-1:0]  held;
  logic [NUM_STAGES:0] inc;
  logic [DATA_W-1:0]   held_b [1:NUM_STAGES-1];
  logic [DATA_W-1:0]   hund_b;

  assign read_act   = !cs_n && !rd_n;
  assign write_act  = !cs_n && !wr_n && rd_n;
  assign hold       = read_act || write_act;
  assign snap_pulse = read_act && !read_act_q && (addr == '0);
  assign cmd_run    = cmd_q[CMD_RUN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      read_act_q <= 1'b0;
      cmd_q      <= '0;
    end else begin
      read_act_q <= read_act;
      if (write_act && addr == ADDR_W'(ADDR_CMD)) cmd_q <= wdata;
    end
  end

  rtc_tick_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_100hz),
    .run     (cmd_run),
    .hold    (hold),
    .step    (step),
    .pending (pending)
  );

  assign inc[0]   = step;
  assign day_roll = inc[NUM_STAGES];

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    localparam int MODV = stage_mod(i);
    localparam int WV   = stage_width(i);
    localparam int LSB  = stage_lsb(i);
    logic [WV-1:0] val;

    rtc_count_stage #(.MOD(MODV), .DATA_W(DATA_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (inc[i]),
      .ld      (write_act && addr == ADDR_W'(i)),
      .ld_data (wdata),
      .val     (val),
      .carry   (inc[i+1])
    );
    assign live[LSB +: WV] = val;
    if (i > 0) begin : g_rd
      assign held_b[i] = DATA_W'(held[LSB +: WV]);
    end
  end

  assign hund_b = DATA_W'(live[stage_width(0)-1:0]);

  rtc_snap_latch #(.LIVE_W(LIVE_W), .LATCH_W(LATCH_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (snap_pulse),
    .live    (live),
    .held    (held)
  );

  always_comb begin
    rdata = '0;
    if (read_act) begin
      if (addr == '0) rdata = hund_b;
      for (int i = 1; i < NUM_STAGES; i++)
        if (addr == ADDR_W'(i)) rdata = held_b[i];
      if (addr == ADDR_W'(ADDR_CMD))     rdata = cmd_q;
      if (addr == ADDR_W'(ADDR_CMD + 1)) rdata = held[LIVE_W +: DATA_W];
      if (addr == ADDR_W'(ADDR_CMD + 2)) rdata = DATA_W'(held[LATCH_W-1 -: SPARE_HI_W]);
    end
  end

  // R7: time is frozen across consecutive read clocks
  a_r7_frozen_read: assert property (@(posedge clk) disable iff (!rst_n)
    (read_act && read_act_q) |-> $stable(live));

  // R4: a full-day carry leaves every field at zero
  a_r4_day_roll: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll |=> (live == '0));

  // R3: stopped, nothing held, no write: time holds still
  a_r3_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_run && !pending && !write_act) |=> $stable(live));

  // R9: the command register cannot change during a read
  a_r9_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    read_act |=> $stable(cmd_q));

endmodule

// File: tb/tb_rtc_snapshot_counters.sv
module tb_rtc_snapshot_counters;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_100hz = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int  mcnt [4];
  int  mlat [4];
  int  mcmd, mpend;
  bit  mra_prev;
  int  mods [4] = '{100, 60, 60, 24};

  always #2 clk = ~clk;

  rtc_snapshot_counters dut (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always @(posedge clk) begin
    bit ra, wa, hld, et, stp;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin mcnt[i] = 0; mlat[i] = 0; end
      mcmd = 0; mpend = 0; mra_prev = 0;
    end else begin
      ra  = !cs_n && !rd_n;
      wa  = !cs_n && !wr_n && rd_n;
      hld = ra || wa;
      et  = tick_100hz && mcmd[3];
      if (ra && !mra_prev && addr == 0)
        for (int i = 0; i < 4; i++) mlat[i] = mcnt[i];
      stp   = !hld && (mpend != 0 || et);
      mpend = hld ? int'(mpend != 0 || et) : int'(mpend != 0 && et);
      if (wa) begin
        if (addr < 4) mcnt[addr] = (int'(wdata) >= mods[addr]) ? 0 : int'(wdata);
        else if (addr == 4) mcmd = int'(wdata);
      end
      if (stp)
        for (int i = 0; i < 4; i++) begin
          if (mcnt[i] == mods[i] - 1) mcnt[i] = 0;
          else begin mcnt[i] = mcnt[i] + 1; break; end
        end
      mra_prev = ra;
    end
  end

  function automatic int model_rdata();
    if (cs_n || rd_n) return 0;
    case (addr)
      3'd0: return mcnt[0];
      3'd1, 3'd2, 3'd3: return mlat[addr];
      3'd4: return mcmd;
      default: return 0;
    endcase
  endfunction

  // per-cycle comparison against the model (R1 idle, R2/R6 reads)
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      checks++;
      if (int'(rdata) != model_rdata()) begin
        errors++;
        $display("FAIL R2 model compare addr=%0d actual=%0d expected=%0d",
                 addr, rdata, model_rdata());
      end
    end
  end

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk);
    cs_n = 0; rd_n = 0; addr = 3'(a); tick_100hz = 0;
    #1;
    checks++;
    if (int'(rdata) != exp) begin
      errors++;
      $display("FAIL %s read addr=%0d actual=%0d expected=%0d", tag, a, rdata, exp);
    end
    @(negedge clk);
    cs_n = 1; rd_n = 1;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cs_n = 0; wr_n = 0; addr = 3'(a); wdata = 8'(d); tick_100hz = 0;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
  endtask

  task automatic run_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_100hz = 1;
      @(negedge clk); tick_100hz = 0;
    end
  endtask

  // read held for n clocks; ticks on clocks 2..k+1; optional tick at release
  task automatic rd_hold(input int a, input int n, input int k, input bit trel);
    @(negedge clk);
    cs_n = 0; rd_n = 0; addr = 3'(a); tick_100hz = 0;
    for (int c = 1; c < n; c++) begin
      @(negedge clk); tick_100hz = (c <= k);
    end
    @(negedge clk);
    cs_n = 1; rd_n = 1; tick_100hz = trel;
    @(negedge clk);
    tick_100hz = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state through every address
    for (int a = 0; a < 8; a++) rd(a, 0, "R1");
    // R3 stopped: ticks ignored
    run_ticks(5);
    rd(0, 0, "R3");
    // R4 set just before midnight, run across it
    wr(0, 98); wr(1, 59); wr(2, 59); wr(3, 23);
    wr(4, 8'h08);
    rd(4, 8, "R2");
    run_ticks(1);
    rd(0, 99, "R4");
    rd(1, 59, "R6"); rd(2, 59, "R6"); rd(3, 23, "R6");
    run_ticks(1);
    rd(0, 0, "R4");
    rd(1, 0, "R4"); rd(2, 0, "R4"); rd(3, 0, "R4");
    rd(5, 0, "R2"); rd(6, 0, "R2"); rd(7, 0, "R2");
    // R5 out-of-range loads
    wr(4, 0);
    wr(1, 10); rd(0, 0, "R5"); rd(1, 10, "R5");
    wr(1, 75); wr(0, 150);
    rd(0, 0, "R5"); rd(1, 0, "R5");
    // R5 writes leave the latch alone; R6 new snapshot
    wr(1, 30); rd(0, 0, "R6");
    wr(1, 45); rd(1, 30, "R5");
    rd(0, 0, "R6"); rd(1, 45, "R6");
    // R7 one tick deferred across a read
    wr(4, 8'h08); wr(0, 10);
    rd_hold(0, 6, 1, 0);
    rd(0, 11, "R7");
    // R8 extra ticks during one read are dropped
    rd_hold(0, 8, 4, 0);
    rd(0, 12, "R8");
    // R9 write overlapping a read is blocked
    @(negedge clk);
    cs_n = 0; rd_n = 0; wr_n = 0; addr = 3'd1; wdata = 8'd7;
    @(negedge clk);
    cs_n = 1; rd_n = 1; wr_n = 1;
    rd(0, 12, "R9"); rd(1, 45, "R9");
    // R9 tick during a write is deferred
    @(negedge clk);
    cs_n = 0; wr_n = 0; addr = 3'd2; wdata = 8'd5; tick_100hz = 1;
    @(negedge clk);
    cs_n = 1; wr_n = 1; tick_100hz = 0;
    rd(0, 13, "R9"); rd(2, 5, "R9");
    // R7 held tick plus a fresh tick at release: both applied
    rd_hold(0, 4, 1, 1);
    rd(0, 15, "R7");
    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule